// File: doc/BRIEF.md
# Segment Offset Guard

The block turns a segment-relative access request into up to four byte addresses and decides, in the cycle of the request, whether that access is a protection fault. It owns a 16-bit stack pointer and steps it for every push and pop that goes ahead. A request carries an access kind (code fetch, data, push, pop), a size of one, two or four bytes, a 32-bit offset for code and data, the segment limit, and a mode bit.

In legacy mode the block computes everything modulo 64K. The upper half of the offset is ignored, byte addresses wrap from FFFFh to 0, and nothing faults. In protected mode the block checks the last byte of the access against the limit at full 32-bit width with a carry, so an access never wraps. The only wrap it allows is in stack pointer arithmetic: a push from SP 0 lands at FFFEh. A stack access whose bytes would straddle FFFFh and 0 faults instead. A faulting request drives no byte lanes and leaves the stack pointer untouched.

Top module: `seg_offset_guard`

## Requirements
- R1: With `prot_mode`=0, no request faults, offset bits 31..16 are ignored, and lane i carries address (base + i) mod 10000h.
- R2: With `prot_mode`=0, a two-byte access at FFFFh drives FFFFh on lane 0 and 0 on lane 1.
- R3: With `prot_mode`=1, a code or data access faults exactly when offset + bytes - 1, computed without truncation, exceeds `seg_limit`. An access ending on the limit is legal.
- R4: With `prot_mode`=1 and no fault, lane i carries offset + i at full 32-bit width, with no 64K wrap.
- R5: `kind` uses 0 = code, 1 = data, 2 = push, 3 = pop. A push accesses SP - bytes and then sets SP to that value. A pop accesses SP and then sets SP to SP + bytes. Both calculations are 16-bit.
- R6: With `prot_mode`=1 and SP = 0, a two-byte push accesses FFFEh and FFFFh, does not fault, and leaves SP = FFFEh.
- R7: With `prot_mode`=1, a stack access faults when its bytes cross from FFFFh to 0, or when its last byte exceeds `seg_limit`.
- R8: `fault` is valid in the cycle of the request. While it is high, `lane_en` is 0 and SP is not stepped.
- R9: `size_sel` 0, 1 and 2 select 1, 2 and 4 bytes, and 3 also selects 4. Lanes 0 to bytes-1 are enabled for an accepted request. A disabled lane drives address 0.
- R10: Reset sets SP to 0. `sp_load` writes `sp_load_val` into SP and takes priority over a stack step in the same cycle, while the access itself still proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| prot_mode | input | 1 | 0 legacy wrap, 1 limit checking |
| kind | input | 2 | 0 code, 1 data, 2 push, 3 pop |
| size_sel | input | 2 | 0:1 byte, 1:2 bytes, 2/3:4 bytes |
| offset | input | 32 | Offset for code and data accesses |
| seg_limit | input | 32 | Highest legal offset in protected mode |
| sp_load | input | 1 | Write the stack pointer |
| sp_load_val | input | 16 | Value for the stack pointer write |
| fault | output | 1 | Protection fault for the current request |
| lane_en | output | 4 | Byte lane enables |
| lane_addr | output | 128 | Four 32-bit byte addresses, lane 0 in bits 31..0 |
| sp_out | output | 16 | Current stack pointer |

## Verification
The bench builds the block with its default widths: 32-bit offsets and a 16-bit stack pointer. These widths put both carries within reach. One is the 33rd-bit carry, where a limit of FFFFFFFFh meets a four-byte access at its top. The other is the 16-bit stack carry, where SP moves between 0 and FFFEh and unaligned pointers straddle FFFFh. Directed vectors target each boundary, and biased random vectors then concentrate offsets around the limit and SP around both ends of the 64K range.

// File: rtl/seg_offset_guard.sv
module seg_offset_guard #(
  parameter int OFS_W = 32,
  parameter int SP_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 prot_mode,
  input  logic [1:0]           kind,
  input  logic [1:0]           size_sel,
  input  logic [OFS_W-1:0]     offset,
  input  logic [OFS_W-1:0]     seg_limit,
  input  logic                 sp_load,
  input  logic [SP_W-1:0]      sp_load_val,
  output logic                 fault,
  output logic [3:0]           lane_en,
  output logic [4*OFS_W-1:0]   lane_addr,
  output logic [SP_W-1:0]      sp_out
);
  localparam int LANES = 4;

  logic [2:0]       nbytes;
  logic [SP_W-1:0]  sp_q, nb_sp, stk_base;
  logic [SP_W:0]    stk_end;
  logic [OFS_W-1:0] base;
  logic [OFS_W:0]   last_wide;
  logic             is_stack, is_push, stk_cross, over_limit, commit;

  always_comb
    case (size_sel)
      2'd0:    nbytes = 3'd1;
      2'd1:    nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase

  assign is_stack  = kind[1];
  assign is_push   = (kind == 2'd2);
  assign nb_sp     = SP_W'(nbytes);
  assign stk_base  = is_push ? sp_q - nb_sp : sp_q;
  assign stk_end   = {1'b0, stk_base} + (SP_W+1)'(nbytes) - 1'b1;
  assign stk_cross = is_stack & stk_end[SP_W];

  assign base       = is_stack ? OFS_W'(stk_base) : offset;
  assign last_wide  = {1'b0, base} + (OFS_W+1)'(nbytes) - 1'b1;
  assign over_limit = last_wide > {1'b0, seg_limit};

  assign fault  = req_valid & prot_mode & (over_limit | stk_cross);
  assign commit = req_valid & is_stack & ~fault;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OFS_W-1:0] full;
    assign full = base + OFS_W'(i);
    assign lane_en[i] = req_valid & ~fault & (3'(i) < nbytes);
    assign lane_addr[i*OFS_W +: OFS_W] = !lane_en[i] ? '0 :
                                         prot_mode   ? full :
                                                       OFS_W'(full[SP_W-1:0]);
  end

  always_ff @(posedge clk)
    if (!rst_n)      sp_q <= '0;
    else if (sp_load) sp_q <= sp_load_val;
    else if (commit)  sp_q <= is_push ? stk_base : sp_q + nb_sp;

  assign sp_out = sp_q;

  AST_LEGACY_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_mode |-> !fault); // R1
  AST_NO_LANES_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> lane_en == 4'b0); // R8
  AST_SP_FROZEN_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !sp_load) |=> sp_out == $past(sp_out)); // R8
  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    lane_en inside {4'b0000, 4'b0001, 4'b0011, 4'b1111}); // R9
  AST_PROT_START_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_mode && lane_en[0]) |-> lane_addr[OFS_W-1:0] <= seg_limit); // R3
  AST_IDLE_SP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !sp_load) |=> $stable(sp_out)); // R5
endmodule

// File: tb/seg_offset_guard_tb.sv
`timescale 1ns/1ps
module seg_offset_guard_tb;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, prot_mode = 0, sp_load = 0;
  logic [1:0]  kind = 0, size_sel = 0;
  logic [31:0] offset = 0, seg_limit = 0;
  logic [15:0] sp_load_val = 0;
  logic        fault;
  logic [3:0]  lane_en;
  logic [127:0] lane_addr;
  logic [15:0] sp_out;

  int vectors = 0, errors = 0;
  longint m_sp = 0;

  always #10 clk = ~clk;

  seg_offset_guard u_dut (.clk, .rst_n, .req_valid, .prot_mode, .kind, .size_sel,
    .offset, .seg_limit, .sp_load, .sp_load_val, .fault, .lane_en, .lane_addr, .sp_out);

  task automatic apply(string tag, bit v, bit pm, logic [1:0] k, logic [1:0] sz,
                       logic [31:0] ofs, logic [31:0] lim, bit ld, logic [15:0] ldv);
    longint nb, b, lastb;
    bit stack, push, ef;
    logic [3:0] een;
    logic [127:0] ea;
    @(negedge clk);
    req_valid = v; prot_mode = pm; kind = k; size_sel = sz;
    offset = ofs; seg_limit = lim; sp_load = ld; sp_load_val = ldv;
    #5;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    stack = k[1]; push = (k == 2);
    b = stack ? (push ? ((m_sp - nb) & 'hFFFF) : m_sp) : longint'(ofs);
    lastb = b + nb - 1;
    ef = v && pm && (lastb > longint'(lim) || (stack && lastb > 'hFFFF));
    een = 0; ea = 0;
    for (int i = 0; i < 4; i++)
      if (v && !ef && i < nb) begin
        een[i] = 1;
        ea[i*32 +: 32] = pm ? 32'(b + i) : 32'((b + i) & 'hFFFF);
      end
    vectors++;
    if (fault !== ef || lane_en !== een || lane_addr !== ea || sp_out !== 16'(m_sp)) begin
      errors++;
      $display("FAIL %s: fault=%0b lane_en=%b addr=%h sp=%h expected fault=%0b lane_en=%b addr=%h sp=%h",
               tag, fault, lane_en, lane_addr, sp_out, ef, een, ea, 16'(m_sp));
    end
    if (ld) m_sp = ldv;
    else if (v && stack && !ef) m_sp = push ? b : ((m_sp + nb) & 'hFFFF);
    @(posedge clk);
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    apply("R10 reset", 0, 0, 0, 0, 0, 0, 0, 0);
    apply("R2 legacy word wrap", 1, 0, 1, 1, 32'h0000FFFF, 0, 0, 0);
    apply("R1 legacy dword high bits", 1, 0, 1, 2, 32'h0012FFFE, 0, 0, 0);
    apply("R1 legacy code byte", 1, 0, 0, 0, 32'hABCD1234, 0, 0, 0);
    apply("R3 ends on limit", 1, 1, 1, 1, 32'h00001FFE, 32'h00001FFF, 0, 0);
    apply("R3 one past limit", 1, 1, 0, 1, 32'h00001FFF, 32'h00001FFF, 0, 0);
    apply("R3 33-bit carry", 1, 1, 1, 2, 32'hFFFFFFFE, 32'hFFFFFFFF, 0, 0);
    apply("R4 no 64K wrap", 1, 1, 1, 2, 32'h0000FFFE, 32'h0002FFFF, 0, 0);
    apply("R9 size 3 as dword", 1, 1, 1, 3, 32'h00000100, 32'h0000FFFF, 0, 0);
    apply("R10 load sp zero", 0, 1, 0, 0, 0, 0, 1, 16'h0000);
    apply("R6 aligned push wrap", 1, 1, 2, 1, 0, 32'h0000FFFF, 0, 0);
    apply("R5 pop back to zero", 1, 1, 3, 1, 0, 32'h0000FFFF, 0, 0);
    apply("R10 load sp one", 0, 1, 0, 0, 0, 0, 1, 16'h0001);
    apply("R7 unaligned push cross", 1, 1, 2, 1, 0, 32'h0000FFFF, 0, 0);
    apply("R8 sp held after fault", 0, 1, 0, 0, 0, 0, 1, 16'hFFFF);
    apply("R7 unaligned pop cross", 1, 1, 3, 1, 0, 32'h0000FFFF, 0, 0);
    apply("R10 load sp 9000", 0, 1, 0, 0, 0, 0, 1, 16'h9000);
    apply("R7 stack past limit", 1, 1, 3, 1, 0, 32'h00007FFF, 0, 0);
    apply("R5 push dword", 1, 1, 2, 2, 0, 32'h0000FFFF, 0, 0);
    apply("R10 load wins over push", 1, 1, 2, 1, 0, 32'h0000FFFF, 1, 16'h0002);
    apply("R5 legacy push dword cross", 1, 0, 2, 2, 0, 0, 0, 0);
    apply("R8 fault blocks lanes", 1, 1, 1, 0, 32'h00000010, 32'h0000000F, 0, 0);
    for (int n = 0; n < 600; n++) begin
      logic [31:0] lim, ofs;
      logic [1:0] k;
      bit pm;
      lim = ($urandom_range(0, 3) == 0) ? 32'hFFFFFFFF : 32'($urandom_range(0, 'h1FFFF));
      ofs = lim - 32'($urandom_range(0, 6)) + 32'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) ofs = $urandom;
      k = 2'($urandom_range(0, 3));
      pm = 1'($urandom_range(0, 1));
      apply(pm ? (k[1] ? "R7 random stack" : "R3 random limit") : "R1 random legacy",
            1'($urandom_range(0, 7) != 0), pm, k, 2'($urandom_range(0, 3)), ofs, lim,
            $urandom_range(0, 9) == 0,
            16'($urandom_range(0, 1) ? $urandom_range(0, 5) : 'hFFFF - $urandom_range(0, 5)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule